// File: doc/BRIEF.md
# Serial Memory Read Slave

This block is a two-wire serial bus slave that sits in front of a 256-byte memory and answers reads from it. The bus lines are sampled as ordinary inputs in a fast system clock domain (at least eight times the serial clock rate). The block recognises bus start and stop conditions, compares the first byte of every transfer against its own 7-bit device address, and pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero bit.

One internal byte pointer decides which memory location is sent next. A master loads it by starting a write that carries only a one-byte word address. If the master follows that write with a repeated start and a read header, the transfer becomes a random read. A read header with no write in front of it sends from wherever the pointer was left. Each byte sent moves the pointer on by one, wrapping from 255 to 0. The master keeps a read going by acknowledging each byte, and ends it by withholding the acknowledge and then issuing a stop. The memory is a plain synchronous array with its own write port, so the surrounding system or a testbench can fill it.

Top module: `i2c_mem_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Clock pulses that arrive after a stop, with no new start, are never acknowledged.
- R2: The first byte after a start carries the device address in bits 7..1 (default 7'h50) and the direction in bit 0 (1 = read). On a match the slave holds the data line low for the whole ninth clock. On a mismatch it never drives the line until the next start or stop.
- R3: In a write (bit 0 = 0), the byte after the header is the word address. The slave acknowledges it and loads it into the pointer. A repeated start followed by a read header then sends the byte stored at that address.
- R4: Read data leaves most significant bit first, one bit per clock. The slave changes the data line only while the clock line is low, so every bit is stable for the whole high period.
- R5: When the master acknowledges a data byte, the slave sends the byte at the next address. The address wraps from 255 to 0.
- R6: When the master does not acknowledge a data byte, the slave releases the data line and sends nothing more. The pointer is left one past the last byte sent.
- R7: A read header with no word-address write in front of it sends from the current pointer value.
- R8: A stop that arrives right after the word address leaves the pointer at the loaded address.
- R9: Any byte written after the word address gets no acknowledge and does not change the pointer.
- R10: After reset the data line is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| ld_we | input | 1 | Memory fill write enable |
| ld_addr | input | AW | Memory fill address |
| ld_data | input | 8 | Memory fill data |

## Verification
The bench targets these corner cases:
- **Sequential read across 255.** It starts a sequential read close to address 255 so the pointer must wrap. A pointer that saturates at 255, or that grows wider than 8 bits, returns the wrong bytes after the wrap.
- **Pointer after a read.** A current-address read follows a read that ended with no acknowledge. A design that leaves the pointer on the last byte sent, instead of one past it, repeats a byte here.
- **Abandoned writes.** It checks two cases: a write that stops right after the word address, and a write that carries an extra data byte. A design that acknowledges the extra byte, or moves the pointer on a stray write, fails here.
- **Bus traffic not meant for the slave.** It sends headers with the wrong address and clock pulses with no start. A slave that drives the line anyway shows up as a low bit or as an acknowledge where none is expected.

Each read bit is sampled at the start and at the end of its clock-high period, so a data change made too late is caught.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh   <= {sh[STAGES-2:0], raw[g]};
        prev <= sh[STAGES-1];
      end
    end
    assign lvl[g]  = sh[STAGES-1];
    assign rise[g] = sh[STAGES-1] & ~prev;
    assign fall[g] = ~sh[STAGES-1] & prev;
  end
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [BYTE_W-1:0] ld_data
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] FULL_CNT = 4'(BYTE_W);

  logic [1:0] lvl, rise, fall;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, sda_rise, sda_fall;
  logic start_c, stop_c;

  slv_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, rd_data;
  logic [AW-1:0]     ctr;
  logic              rw_q, mst_ack, oe_q;

  i2c_line_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw({sda_i, scl_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_rise = rise[1];
  assign sda_fall = fall[1];
  assign start_c  = scl_lvl & sda_fall;
  assign stop_c   = scl_lvl & sda_rise;

  i2c_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr(ctr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ctr     <= '0;
      rw_q    <= 1'b0;
      mst_ack <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_c) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (start_c) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WADDR: begin
          if (scl_rise && bit_cnt != FULL_CNT) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == FULL_CNT) begin
            bit_cnt <= '0;
            if (state == ST_WADDR) begin
              ctr   <= rx_sh[AW-1:0];
              oe_q  <= 1'b1;
              state <= ST_WADDR_ACK;
            end else if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
              rw_q  <= rx_sh[0];
              oe_q  <= 1'b1;
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              oe_q    <= ~rd_data[BYTE_W-1];
              tx_sh   <= {rd_data[BYTE_W-2:0], 1'b0};
              bit_cnt <= '0;
              state   <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_SKIP;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              oe_q  <= 1'b0;
              state <= ST_TX_ACK;
            end else begin
              oe_q    <= ~tx_sh[BYTE_W-1];
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_lvl;
            ctr     <= ctr + 1'b1;
          end else if (scl_fall) begin
            if (mst_ack) begin
              oe_q    <= ~rd_data[BYTE_W-1];
              tx_sh   <= {rd_data[BYTE_W-2:0], 1'b0};
              bit_cnt <= '0;
              state   <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl)); // R4
  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_ADDR && state == ST_ADDR_ACK) |-> (rx_sh[BYTE_W-1:1] == DEV_ADDR)); // R2
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_ACK || state == ST_WADDR_ACK) |-> sda_oe); // R2
  AST_RELEASE_ON_ACK_SLOT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK) |-> !sda_oe); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe); // R1
  AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK && scl_rise && !start_c && !stop_c) |=> (ctr == AW'($past(ctr) + 1'b1))); // R5
endmodule

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic ld_we = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, fails = 0, stab_err = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ctr = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave #(.DEV_ADDR(DEV), .AW(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] hdr(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic wr_bit(input logic b);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic rd_bit(output logic b);
    logic first;
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(1);
    first = sda_bus;
    wq(2*Q - 1);
    b = sda_bus;
    if (b !== first) stab_err++;
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      v[i] = b;
    end
    wr_bit(~give_ack);
  endtask

  task automatic do_read(input int n, input bit set_addr, input logic [7:0] a, input string req);
    logic ack;
    logic [7:0] d;
    if (set_addr) begin
      bus_start();
      send_byte(hdr(DEV, 1'b0), ack); check({req, " write header ack"}, ack, 1);
      send_byte(a, ack);              check({req, " word address ack"}, ack, 1);
      exp_ctr = a;
    end
    bus_start();
    send_byte(hdr(DEV, 1'b1), ack); check({req, " read header ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      check({req, " data"}, d, exp_mem[exp_ctr]);
      exp_ctr = exp_ctr + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd4242));
    wq(4);
    rst = 1'b0;
    wq(2);
    check("R10 reset release", sda_oe, 0);
    for (int i = 0; i < 256; i++) begin
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = 8'($urandom);
      exp_mem[i] = ld_data;
      wq(1);
    end
    ld_we = 1'b0;
    wq(4);

    // R10 / R7: pointer starts at 0
    do_read(1, 1'b0, 8'h00, "R10 R7 first current read");
    // R3 random read, R6 nack then pointer one past
    do_read(1, 1'b1, 8'h3C, "R3 random read");
    do_read(1, 1'b0, 8'h00, "R6 R7 read after nack");
    // R5 sequential with wrap
    do_read(6, 1'b1, 8'hFD, "R5 wrap sequential");
    check("R4 bit stability", stab_err, 0);

    // R2 mismatch: no ack, line left released
    bus_start();
    send_byte(hdr(7'h23, 1'b1), ack); check("R2 mismatch no ack", ack, 0);
    recv_byte(d, 1'b0);               check("R2 mismatch line released", d, 8'hFF);
    bus_stop();
    bus_start();
    send_byte(hdr(7'h51, 1'b0), ack); check("R2 mismatch write no ack", ack, 0);
    send_byte(8'h10, ack);            check("R2 ignored byte no ack", ack, 0);
    bus_stop();
    do_read(1, 1'b0, 8'h00, "R2 pointer untouched");

    // R1 clock pulses with no start
    m_scl = 1'b0; wq(Q);
    send_byte(hdr(DEV, 1'b1), ack); check("R1 no start no ack", ack, 0);
    m_scl = 1'b1; wq(2*Q);
    do_read(1, 1'b0, 8'h00, "R1 normal after stray clocks");

    // R8 stop right after word address
    bus_start();
    send_byte(hdr(DEV, 1'b0), ack); check("R8 header ack", ack, 1);
    send_byte(8'h9A, ack);          check("R8 word address ack", ack, 1);
    bus_stop();
    exp_ctr = 8'h9A;
    do_read(2, 1'b0, 8'h00, "R8 current read after stop");

    // R9 data byte after word address
    bus_start();
    send_byte(hdr(DEV, 1'b0), ack); check("R9 header ack", ack, 1);
    send_byte(8'h20, ack);          check("R9 word address ack", ack, 1);
    send_byte(8'h77, ack);          check("R9 extra byte no ack", ack, 0);
    bus_stop();
    exp_ctr = 8'h20;
    do_read(1, 1'b0, 8'h00, "R9 pointer at word address");

    // random mix of random and current reads
    for (int it = 0; it < 20; it++) begin
      int n;
      bit mode;
      logic [7:0] a;
      n = 1 + int'($urandom % 4);
      mode = 1'($urandom);
      a = 8'($urandom);
      do_read(n, mode, a, mode ? "R3 R5 random mix" : "R7 R5 random mix");
    end
    check("R4 bit stability final", stab_err, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule